// File: doc/BRIEF.md
# Two-Channel Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. An external master drives the bit clock, the word-select (frame) clock and the serial data line. The block samples all three with a faster system clock through two-flop synchronizers and detects the bit-clock rising edges in the system domain. On each detected rising edge it takes one data bit and one word-select bit.

A change of word-select marks the boundary between two channel slots. Each slot is delimited by consecutive word-select changes. At each boundary the block measures the length of the slot that just ended in bit clocks. It then extracts the sample from that slot according to a 2-bit runtime format field. The sample goes out as a 24-bit word with a one-cycle strobe on either the left or the right output. A slot that is too short or too long produces a one-cycle framing-error pulse and no sample.

Top module: `audio_rx_deser`

## Requirements
- R1: With fmt_sel = 2'b00 (I2S framing), the MSB is the second bit of a slot, the 24 bits that follow the first bit form the sample, and a slot with word-select low is the left channel.
- R2: With fmt_sel = 2'b01 (left-justified), the MSB is the first bit of a slot, the first 24 bits form the sample, and a slot with word-select high is the left channel.
- R3: With fmt_sel = 2'b10 (right-justified, 24-bit word), the last 24 bits of a slot form the sample with the LSB in the final bit before the next word-select change, and word-select high is the left channel.
- R4: With fmt_sel = 2'b11 (right-justified, 16-bit word), the last 16 bits of a slot form the word, its bit 15 is copied into output bits 23:16, and word-select high is the left channel.
- R5: A slot is accepted only when it is 32 bit clocks or shorter and at least the minimum for the format: 25 for I2S, 24 for left-justified and right-justified 24-bit, 16 for right-justified 16-bit. Any other slot raises frame_err for one cycle and produces no valid strobe.
- R6: Bits of a slot that lie outside the sample word, including padding and the I2S delay bit, have no effect on the output data.
- R7: Every result (left_valid, right_valid or frame_err) is a single-cycle pulse. It is visible after the third system-clock rising edge that follows the bit-clock rising edge which opens the next slot. At most one of the three is high in any cycle.
- R8: After reset all outputs are zero. The bits before the first word-select change and the first partial slot are discarded and produce neither a sample nor an error.
- R9: left_data and right_data keep their value between their strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified 24-bit, 11 right-justified 16-bit |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word-select (frame) clock |
| sd_in | input | 1 | Serial data |
| left_data | output | 24 | Last left-channel sample |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right-channel sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| frame_err | output | 1 | One-cycle pulse for a rejected slot |

## Verification
A slot's result cannot appear until the next slot opens. It is due exactly three system-clock edges after the bench raises the bit clock for the first bit of that next slot: two synchronizer stages and then the output register. The driver records the cycle of every slot-opening edge and pushes the expected outcome (channel, data or error) into a queue. The monitor samples on the falling system-clock edge, pops one entry for each strobe, and checks the data, the channel and that the latency is exactly three cycles. At the end of each group the queue must be empty and the held data must be unchanged.

// File: rtl/ar_pkg.sv
package ar_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ   = 2'b01,
        FMT_RJ24 = 2'b10,
        FMT_RJ16 = 2'b11
    } fmt_e;

    localparam int OUT_W_DEF    = 24;
    localparam int SHORT_W_DEF  = 16;
    localparam int SLOT_MAX_DEF = 32;

endpackage

// File: rtl/ar_sync.sv
module ar_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
            end
        end
        assign sync_out[i] = sync_q;
    end
endmodule

// File: rtl/ar_bitclk_edge.sv
module ar_bitclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic ws_s,
    input  logic sd_s,
    output logic bit_stb,
    output logic ws_bit,
    output logic sd_bit
);
    logic sck_prev_d, sck_prev_q;

    always_comb begin
        sck_prev_d = sck_s;
        bit_stb    = sck_s & ~sck_prev_q;
        ws_bit     = ws_s;
        sd_bit     = sd_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_prev_d;
    end
endmodule

// File: rtl/ar_slot_track.sv
module ar_slot_track #(
    parameter int SLOT_MAX = 32,
    localparam int CNT_W   = $clog2(SLOT_MAX + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                ws_bit,
    input  logic                sd_bit,
    output logic                slot_done,
    output logic [CNT_W-1:0]    slot_len,
    output logic [SLOT_MAX-1:0] slot_bits,
    output logic                slot_ws
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SLOT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic                primed;
        logic                locked;
        logic                ws_prev;
        logic [CNT_W-1:0]    cnt;
        logic [SLOT_MAX-1:0] sh;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     done_d;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        if (bit_stb) begin
            if (!st_q.primed) begin
                st_d.primed  = 1'b1;
                st_d.ws_prev = ws_bit;
                st_d.cnt     = CNT_ONE;
                st_d.sh      = {{(SLOT_MAX-1){1'b0}}, sd_bit};
            end else if (ws_bit != st_q.ws_prev) begin
                done_d       = st_q.locked;
                st_d.locked  = 1'b1;
                st_d.ws_prev = ws_bit;
                st_d.cnt     = CNT_ONE;
                st_d.sh      = {{(SLOT_MAX-1){1'b0}}, sd_bit};
            end else begin
                if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + CNT_ONE;
                st_d.sh = {st_q.sh[SLOT_MAX-2:0], sd_bit};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_done = done_d;
    assign slot_len  = st_q.cnt;
    assign slot_bits = st_q.sh;
    assign slot_ws   = st_q.ws_prev;
endmodule

// File: rtl/ar_fmt_extract.sv
module ar_fmt_extract
    import ar_pkg::*;
#(
    parameter int OUT_W    = 24,
    parameter int SHORT_W  = 16,
    parameter int SLOT_MAX = 32,
    localparam int CNT_W   = $clog2(SLOT_MAX + 2)
) (
    input  fmt_e                fmt,
    input  logic [SLOT_MAX-1:0] bits,
    input  logic [CNT_W-1:0]    len,
    input  logic                ws,
    output logic [OUT_W-1:0]    data,
    output logic                is_left,
    output logic                len_ok
);
    localparam logic [CNT_W-1:0] NEED_I2S = CNT_W'(OUT_W + 1);
    localparam logic [CNT_W-1:0] NEED_W   = CNT_W'(OUT_W);
    localparam logic [CNT_W-1:0] NEED_S   = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] MAX_LEN  = CNT_W'(SLOT_MAX);

    logic [CNT_W-1:0]    need;
    logic [CNT_W-1:0]    sh_amt;
    logic [SLOT_MAX-1:0] aligned;

    always_comb begin
        need    = NEED_W;
        sh_amt  = '0;
        is_left = ws;
        data    = bits[OUT_W-1:0];
        unique case (fmt)
            FMT_I2S: begin
                need    = NEED_I2S;
                sh_amt  = CNT_W'(SLOT_MAX + 1) - len;
                is_left = ~ws;
            end
            FMT_LJ: begin
                need   = NEED_W;
                sh_amt = MAX_LEN - len;
            end
            FMT_RJ24: begin
                need = NEED_W;
            end
            FMT_RJ16: begin
                need = NEED_S;
                data = {{(OUT_W-SHORT_W){bits[SHORT_W-1]}}, bits[SHORT_W-1:0]};
            end
            default: need = NEED_W;
        endcase
        aligned = bits << sh_amt;
        if (fmt == FMT_I2S || fmt == FMT_LJ)
            data = aligned[SLOT_MAX-1 -: OUT_W];
        len_ok = (len >= need) && (len <= MAX_LEN);
    end
endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser
    import ar_pkg::*;
#(
    parameter int OUT_W    = OUT_W_DEF,
    parameter int SHORT_W  = SHORT_W_DEF,
    parameter int SLOT_MAX = SLOT_MAX_DEF,
    localparam int CNT_W   = $clog2(SLOT_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_sel,
    input  logic             sck_in,
    input  logic             ws_in,
    input  logic             sd_in,
    output logic [OUT_W-1:0] left_data,
    output logic             left_valid,
    output logic [OUT_W-1:0] right_data,
    output logic             right_valid,
    output logic             frame_err
);
    logic [2:0]          sync_v;
    logic                bit_stb, ws_bit, sd_bit;
    logic                slot_done, slot_ws;
    logic [CNT_W-1:0]    slot_len;
    logic [SLOT_MAX-1:0] slot_bits;
    logic [OUT_W-1:0]    ext_data;
    logic                ext_left, ext_ok;

    ar_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck_in, ws_in, sd_in}),
        .sync_out (sync_v)
    );

    ar_bitclk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sync_v[2]),
        .ws_s    (sync_v[1]),
        .sd_s    (sync_v[0]),
        .bit_stb (bit_stb),
        .ws_bit  (ws_bit),
        .sd_bit  (sd_bit)
    );

    ar_slot_track #(.SLOT_MAX(SLOT_MAX)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .ws_bit    (ws_bit),
        .sd_bit    (sd_bit),
        .slot_done (slot_done),
        .slot_len  (slot_len),
        .slot_bits (slot_bits),
        .slot_ws   (slot_ws)
    );

    ar_fmt_extract #(.OUT_W(OUT_W), .SHORT_W(SHORT_W), .SLOT_MAX(SLOT_MAX)) u_ext (
        .fmt     (fmt_e'(fmt_sel)),
        .bits    (slot_bits),
        .len     (slot_len),
        .ws      (slot_ws),
        .data    (ext_data),
        .is_left (ext_left),
        .len_ok  (ext_ok)
    );

    typedef struct packed {
        logic [OUT_W-1:0] ldata;
        logic             lval;
        logic [OUT_W-1:0] rdata;
        logic             rval;
        logic             err;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.lval = 1'b0;
        out_d.rval = 1'b0;
        out_d.err  = 1'b0;
        if (slot_done) begin
            if (!ext_ok) begin
                out_d.err = 1'b1;
            end else if (ext_left) begin
                out_d.ldata = ext_data;
                out_d.lval  = 1'b1;
            end else begin
                out_d.rdata = ext_data;
                out_d.rval  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign left_data   = out_q.ldata;
    assign left_valid  = out_q.lval;
    assign right_data  = out_q.rdata;
    assign right_valid = out_q.rval;
    assign frame_err   = out_q.err;
endmodule

// File: rtl/ar_rx_chk.sv
module ar_rx_chk #(
    parameter int OUT_W   = 24,
    parameter int SHORT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       fmt_sel,
    input logic [OUT_W-1:0] left_data,
    input logic             left_valid,
    input logic [OUT_W-1:0] right_data,
    input logic             right_valid,
    input logic             frame_err
);
    // R7
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_valid, right_valid, frame_err}));

    // R7
    lval_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid || right_valid) |=> !(left_valid || right_valid));

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R9
    ldata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |-> $stable(left_data));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |-> $stable(right_data));

    // R4
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid && fmt_sel == 2'b11 && $past(fmt_sel) == 2'b11)
        |-> (left_data[OUT_W-1:SHORT_W] == {(OUT_W-SHORT_W){left_data[SHORT_W-1]}}));
endmodule

bind audio_rx_deser ar_rx_chk #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_sel     (fmt_sel),
    .left_data   (left_data),
    .left_valid  (left_valid),
    .right_data  (right_data),
    .right_valid (right_valid),
    .frame_err   (frame_err)
);

// File: tb/sim_audio_rx_deser.sv
module sim_audio_rx_deser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] left_data, right_data;
    logic        left_valid, right_valid, frame_err;

    always #10 clk = ~clk;

    audio_rx_deser u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .sck_in(sck), .ws_in(ws), .sd_in(sd),
        .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid),
        .frame_err(frame_err)
    );

    typedef struct {
        int          kind;   // 0 left, 1 right, 2 error
        logic [23:0] data;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0;
    int          rise_cyc = 0;
    int          n_chk = 0, n_bad = 0;
    logic        cur_ws = 1'b0;
    logic [23:0] last_left = '0, last_right = '0;
    bit          finished = 0;

    always @(posedge clk) cyc++;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic drive_bit(logic w, logic d, bit opens);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        if (opens) rise_cyc = cyc;
        repeat (3) @(negedge clk);
    endtask

    task automatic drive_slot(logic [1:0] f, logic w, logic [23:0] v, int len, string tag);
        exp_t e;
        int need;
        need = (f == 2'b00) ? 25 : (f == 2'b11) ? 16 : 24;
        e.tag = tag;
        if (len < need || len > 32) begin
            e.kind = 2; e.data = '0;
        end else begin
            e.kind = ((f == 2'b00) ? (w == 1'b0) : (w == 1'b1)) ? 0 : 1;
            e.data = (f == 2'b11) ? {{8{v[15]}}, v[15:0]} : v;
        end
        q.push_back(e);
        for (int j = 0; j < len; j++) begin
            logic b;
            b = (j % 2 == 0);  // padding pattern (R6)
            case (f)
                2'b00: if (j >= 1 && j <= 24) b = v[24-j];
                2'b01: if (j < 24) b = v[23-j];
                2'b10: if (j >= len - 24) b = v[len-1-j];
                default: if (j >= len - 16) b = v[len-1-j];
            endcase
            drive_bit(w, b, j == 0);
        end
        cur_ws = w;
    endtask

    task automatic start_group(logic [1:0] f, logic first_ws);
        @(negedge clk);
        rst_n = 1'b0; sck = 1'b0; ws = ~first_ws; sd = 1'b0; fmt_sel = f;
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(left_data == 0 && right_data == 0 && !left_valid && !right_valid && !frame_err,
            "R8", "outputs in reset",
            {left_data, right_data, left_valid, right_valid, frame_err}, 0);
        rst_n = 1'b1;
        last_left = '0; last_right = '0;
        // R8: partial preamble slot must be discarded
        drive_bit(~first_ws, 1'b1, 1'b0);
        drive_bit(~first_ws, 1'b0, 1'b0);
        drive_bit(~first_ws, 1'b1, 1'b0);
    endtask

    task automatic end_group(string tag);
        drive_bit(~cur_ws, 1'b1, 1'b1);
        drive_bit(~cur_ws, 1'b0, 1'b0);
        repeat (12) @(negedge clk);
        chk(q.size() == 0, tag, "missing results", q.size(), 0);
        q.delete();
        // R9: data held after the last strobe
        chk(left_data == last_left, "R9", "left held", left_data, last_left);
        chk(right_data == last_right, "R9", "right held", right_data, last_right);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (left_valid || right_valid || frame_err)) begin
            int kind;
            kind = left_valid ? 0 : right_valid ? 1 : 2;
            if (q.size() == 0) begin
                chk(0, "R8", "unexpected result kind", kind, 3);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(kind == e.kind, e.tag, "result kind", kind, e.kind);
                if (kind == 0) begin
                    chk(left_data == e.data, e.tag, "left data", left_data, e.data);
                    last_left = left_data;
                end else if (kind == 1) begin
                    chk(right_data == e.data, e.tag, "right data", right_data, e.data);
                    last_right = right_data;
                end
                // R7: latency from the opening edge of the next slot
                chk(cyc - rise_cyc == 3, "R7", "latency", cyc - rise_cyc, 3);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: left-justified
        start_group(2'b01, 1'b1);
        drive_slot(2'b01, 1'b1, 24'h123456, 32, "R2");
        drive_slot(2'b01, 1'b0, 24'hABCDEF, 32, "R2");
        drive_slot(2'b01, 1'b1, 24'h800001, 24, "R2");
        drive_slot(2'b01, 1'b0, 24'h5A5A5A, 20, "R5");
        end_group("R2");

        // R1: I2S
        start_group(2'b00, 1'b0);
        drive_slot(2'b00, 1'b0, 24'hC3A501, 32, "R1");
        drive_slot(2'b00, 1'b1, 24'h0F1E2D, 25, "R1");
        drive_slot(2'b00, 1'b0, 24'h777777, 24, "R5");
        drive_slot(2'b00, 1'b1, 24'h13579B, 28, "R6");
        end_group("R1");

        // R3: right-justified 24-bit
        start_group(2'b10, 1'b1);
        drive_slot(2'b10, 1'b1, 24'hFEDCBA, 32, "R3");
        drive_slot(2'b10, 1'b0, 24'h000001, 24, "R3");
        drive_slot(2'b10, 1'b1, 24'h2468AC, 30, "R6");
        end_group("R3");

        // R4: right-justified 16-bit
        start_group(2'b11, 1'b1);
        drive_slot(2'b11, 1'b1, 24'h008001, 16, "R4");
        drive_slot(2'b11, 1'b0, 24'h007FFF, 32, "R4");
        drive_slot(2'b11, 1'b1, 24'h001234, 15, "R5");
        drive_slot(2'b11, 1'b0, 24'h00F00F, 34, "R5");
        drive_slot(2'b11, 1'b1, 24'h00C0DE, 20, "R4");
        end_group("R4");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule